// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the mode-control logic between a host register port and a CAN protocol core. It owns one control byte holding four mode bits: a sleep request, a power-down enable, a soft reset and a software-initialisation hold. Sleep and soft reset are not applied at once. They are held pending until the core reports that it is idle between frames. A read of the control byte shows whether each of those two modes is actually engaged, not what was last written.

Sleep ends on bus activity, on a host write, or when reset or initialisation is requested. Leaving sleep, or leaving initialisation while the core is not bus-off, starts a resynchronisation wait. The core is enabled only after 11 consecutive recessive bits have been sampled. When the soft reset engages, the block pulses a clear strobe that wipes the peripheral registers and both error counters. The control byte is then forced to 09h.

Top module: `can_mode_seq`

## Requirements
- R1: A write with control bit 4 (sleep) at 1 while `frame_idle` is 0 leaves read bit 4 and `low_power` at 0. Sleep engages at the first clock edge that samples `frame_idle`=1 with `core_irq`=0 while the request is pending. From the next cycle, read bit 4 and `low_power` are 1.
- R2: `core_irq` sampled at 1 while a sleep request is pending cancels the request. Sleep does not engage later, even when the core becomes idle.
- R3: Engaged sleep is left one cycle after any of these: `bus_act`=1, a write with bit 4 at 0, a write that sets bit 3 (reset) while reset is not engaged, or a write that sets bit 0 (init) from 0 to 1.
- R4: Leaving sleep starts the resynchronisation wait. `core_en` stays 0 until 11 `bit_tick` strobes in a row sample `bus_rx`=1 (recessive). A strobe that samples `bus_rx`=0 restarts the count from zero.
- R5: Bit 1 (power-down enable) and sleep act independently. `low_power` is 1 while either is set and stays 1 until both are clear. Clearing bit 1 alone starts no resynchronisation wait.
- R6: A write with bit 3 at 1 is deferred like sleep, and read bit 3 stays 0 until `frame_idle`=1 is sampled. When the reset engages, the control byte reads 09h (reset and init set; sleep and power-down clear) and `regs_clr` is 1 for exactly one cycle.
- R7: An engaged reset stays engaged until a write with bit 3 at 0. When that write keeps bit 0 at 1, init stays set, the byte reads 01h and `core_en` stays 0. Writing bit 3 at 0 while reset is already clear changes nothing and raises no `regs_clr`.
- R8: A write that clears bit 0 from 1 to 0 while `bus_off`=0 starts the 11-recessive-bit wait. While `bus_off`=1 it starts none, and `core_en` rises in the next cycle.
- R9: `core_en` is 1 only when sleep, power-down, reset and init are all disengaged and no resynchronisation wait is running.
- R10: After `rst` the control byte reads 01h (init only), and `low_power`, `core_en` and `regs_clr` are 0. Read bits 2, 5, 6 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the control byte |
| wr_data | input | 8 | Write data: bit 0 init, bit 1 power-down, bit 3 reset, bit 4 sleep |
| frame_idle | input | 1 | Core idle: frame finished, lost-arbitration frame received, or error handled |
| core_irq | input | 1 | Interrupt raised by an active transmit or receive |
| bus_act | input | 1 | Bus activity detected (wake source) |
| bus_off | input | 1 | Core is in the bus-off state |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| rd_ctrl | output | 8 | Control byte read value showing engaged modes |
| regs_clr | output | 1 | One-cycle strobe clearing peripheral registers and error counters |
| low_power | output | 1 | Core held in low power |
| core_en | output | 1 | Core allowed to run normally |

## Verification
The resynchronisation wait is swept with one dominant bit placed after each possible number of recessive bits, from 0 to 10. A correct design has to re-count the full 11 bits every time, so a counter that does not restart, or that ends one bit early or late, is caught. Sleep is entered and left through each of its four exit routes in turn, which shows which route fails to wake the core or fails to start the wait. Deferred sleep and reset are held for several busy cycles before the idle indication arrives. This separates engaged from written read-back, and an interrupt during the pending window shows that a cancelled request is not remembered. Power-down and sleep are interleaved to show that the two low-power sources are kept apart.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    localparam int CTRL_W    = 8;
    localparam int BIT_INIT  = 0;
    localparam int BIT_PDE   = 1;
    localparam int BIT_RST   = 3;
    localparam int BIT_SLEEP = 4;
    localparam int RESYNC_BITS_DEF = 11;

    typedef struct packed {
        logic sleep_on;
        logic rst_on;
        logic pde;
        logic init;
    } mode_t;

    function automatic logic [CTRL_W-1:0] pack_ctrl(input mode_t m);
        logic [CTRL_W-1:0] v;
        v            = '0;
        v[BIT_INIT]  = m.init;
        v[BIT_PDE]   = m.pde;
        v[BIT_RST]   = m.rst_on;
        v[BIT_SLEEP] = m.sleep_on;
        return v;
    endfunction
endpackage

// File: rtl/can_defer_req.sv
module can_defer_req (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic cancel,
    input  logic idle,
    output logic on,
    output logic pend,
    output logic engage
);
    logic set_new;

    assign set_new = set_req & ~on;
    assign engage  = ~clr_req & ~set_new & pend & ~cancel & idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            on   <= 1'b0;
            pend <= 1'b0;
        end else if (clr_req) begin
            on   <= 1'b0;
            pend <= 1'b0;
        end else if (set_new) begin
            pend <= 1'b1;
        end else if (pend && cancel) begin
            pend <= 1'b0;
        end else if (engage) begin
            on   <= 1'b1;
            pend <= 1'b0;
        end
    end

    // R1
    engage_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(on) |-> $past(idle));

    // R2
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && cancel && !clr_req && !set_req) |=> (!on && !pend));

    // R1
    pend_on_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pend && on));
endmodule

// File: rtl/can_resync.sv
module can_resync #(
    parameter int NBITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic busy
);
    localparam int CNT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy && bit_tick) begin
            if (!bus_rx) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    dom_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bit_tick && !bus_rx && !start) |=> (busy && cnt == '0));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt <= LAST) && (busy || cnt == '0));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int RESYNC_BITS = RESYNC_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              frame_idle,
    input  logic              core_irq,
    input  logic              bus_act,
    input  logic              bus_off,
    input  logic              bit_tick,
    input  logic              bus_rx,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic              regs_clr,
    output logic              low_power,
    output logic              core_en
);
    logic  init_q, pde_q, regs_clr_q;
    logic  sleep_on, sleep_pend, sleep_engage;
    logic  rst_on, rst_pend, rst_engage;
    logic  init_rise_wr, rst_set_wr, init_fall;
    logic  sleep_set, sleep_clr, sleep_leave;
    logic  rst_set, rst_clr;
    logic  resync_start, resync_busy;
    mode_t mode;

    assign init_rise_wr = wr_en & wr_data[BIT_INIT] & ~init_q;
    assign rst_set_wr   = wr_en & wr_data[BIT_RST] & ~rst_on;
    assign init_fall    = wr_en & ~wr_data[BIT_INIT] & init_q & ~bus_off;

    assign rst_set = wr_en & wr_data[BIT_RST];
    assign rst_clr = wr_en & ~wr_data[BIT_RST];

    assign sleep_set = wr_en & wr_data[BIT_SLEEP];
    assign sleep_clr = (wr_en & ~wr_data[BIT_SLEEP]) | (bus_act & sleep_on)
                     | init_rise_wr | rst_set_wr | rst_engage;
    assign sleep_leave  = sleep_on & sleep_clr;
    assign resync_start = sleep_leave | init_fall;

    can_defer_req u_rst_defer (
        .clk     (clk),
        .rst     (rst),
        .set_req (rst_set),
        .clr_req (rst_clr),
        .cancel  (1'b0),
        .idle    (frame_idle),
        .on      (rst_on),
        .pend    (rst_pend),
        .engage  (rst_engage)
    );

    can_defer_req u_sleep_defer (
        .clk     (clk),
        .rst     (rst),
        .set_req (sleep_set),
        .clr_req (sleep_clr),
        .cancel  (core_irq),
        .idle    (frame_idle),
        .on      (sleep_on),
        .pend    (sleep_pend),
        .engage  (sleep_engage)
    );

    can_resync #(.NBITS(RESYNC_BITS)) u_resync (
        .clk      (clk),
        .rst      (rst),
        .start    (resync_start),
        .bit_tick (bit_tick),
        .bus_rx   (bus_rx),
        .busy     (resync_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q     <= 1'b1;
            pde_q      <= 1'b0;
            regs_clr_q <= 1'b0;
        end else begin
            regs_clr_q <= rst_engage;
            if (rst_engage) begin
                init_q <= 1'b1;
                pde_q  <= 1'b0;
            end else if (wr_en) begin
                init_q <= wr_data[BIT_INIT];
                pde_q  <= wr_data[BIT_PDE];
            end
        end
    end

    always_comb begin
        mode.sleep_on = sleep_on;
        mode.rst_on   = rst_on;
        mode.pde      = pde_q;
        mode.init     = init_q;
    end

    assign rd_ctrl   = pack_ctrl(mode);
    assign regs_clr  = regs_clr_q;
    assign low_power = sleep_on | pde_q;
    assign core_en   = ~(sleep_on | pde_q | rst_on | init_q | resync_busy);

    // R6
    clr_value_chk: assert property (@(posedge clk) disable iff (rst)
        regs_clr |-> (rd_ctrl == 8'h09));

    // R3
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_on && bus_act) |=> !sleep_on);

    // R8
    init_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[BIT_INIT] && init_q && !bus_off) |=> !core_en);

    // R1
    sleep_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_on) |-> ($past(sleep_pend) && $past(sleep_engage)));

    // R6
    rst_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_on) |-> $past(rst_pend));
endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 11;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       frame_idle = 1'b1;
    logic       core_irq = 1'b0;
    logic       bus_act = 1'b0;
    logic       bus_off = 1'b0;
    logic       bit_tick = 1'b0;
    logic       bus_rx = 1'b1;
    logic [7:0] rd_ctrl;
    logic       regs_clr, low_power, core_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    can_mode_seq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .frame_idle(frame_idle), .core_irq(core_irq), .bus_act(bus_act),
        .bus_off(bus_off), .bit_tick(bit_tick), .bus_rx(bus_rx),
        .rd_ctrl(rd_ctrl), .regs_clr(regs_clr), .low_power(low_power),
        .core_en(core_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic lvl);
        bit_tick = 1'b1; bus_rx = lvl;
        cyc();
        bit_tick = 1'b0; bus_rx = 1'b1;
        cyc();
    endtask

    task automatic finish_resync(input string tag);
        chk({tag, " busy"}, {7'b0, core_en}, 8'h00);
        repeat (NB - 1) tick(1'b1);
        chk({tag, " before last bit"}, {7'b0, core_en}, 8'h00);
        tick(1'b1);
        chk({tag, " after 11 bits"}, {7'b0, core_en}, 8'h01);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R10 reset state
        chk("R10 ctrl after reset", rd_ctrl, 8'h01);
        chk("R10 low_power", {7'b0, low_power}, 8'h00);
        chk("R10 core_en", {7'b0, core_en}, 8'h00);
        chk("R10 regs_clr", {7'b0, regs_clr}, 8'h00);

        // R8 init exit while bus-off: no wait
        bus_off = 1'b1;
        wr(8'h00);
        chk("R8 bus-off init exit core_en", {7'b0, core_en}, 8'h01);
        bus_off = 1'b0;

        // R4 / R8: dominant bit after d recessive bits restarts the count
        for (int d = 0; d < NB; d++) begin
            wr(8'h01);
            wr(8'h00);
            repeat (d) tick(1'b1);
            tick(1'b0);
            finish_resync("R4 sweep");
        end

        // R1 deferred sleep
        frame_idle = 1'b0;
        wr(8'h10);
        for (int k = 0; k < 3; k++) begin
            chk("R1 pending read bit4", {7'b0, rd_ctrl[4]}, 8'h00);
            chk("R1 pending low_power", {7'b0, low_power}, 8'h00);
            cyc();
        end
        frame_idle = 1'b1;
        cyc();
        chk("R1 engaged read", rd_ctrl, 8'h10);
        chk("R1 engaged low_power", {7'b0, low_power}, 8'h01);
        chk("R9 core_en in sleep", {7'b0, core_en}, 8'h00);

        // R3 each wake route, followed by the R4 wait
        for (int m = 0; m < 4; m++) begin
            if (m > 0) begin
                frame_idle = 1'b1;
                wr(8'h10);
                cyc();
                chk("R3 sleep re-entered", {7'b0, low_power}, 8'h01);
            end
            case (m)
                0: begin bus_act = 1'b1; cyc(); bus_act = 1'b0; end
                1: wr(8'h00);
                2: begin frame_idle = 1'b0; wr(8'h18); end
                default: wr(8'h11);
            endcase
            chk("R3 woken read bit4", {7'b0, rd_ctrl[4]}, 8'h00);
            chk("R3 woken low_power", {7'b0, low_power}, 8'h00);
            if (m == 2) begin
                chk("R6 reset still pending", {7'b0, rd_ctrl[3]}, 8'h00);
                wr(8'h00);
                frame_idle = 1'b1;
            end
            if (m == 3) wr(8'h00);
            finish_resync("R3 wake resync");
        end

        // R2 interrupt cancels pending sleep
        frame_idle = 1'b0;
        wr(8'h10);
        core_irq = 1'b1; cyc(); core_irq = 1'b0;
        frame_idle = 1'b1;
        repeat (3) cyc();
        chk("R2 cancelled read", rd_ctrl, 8'h00);
        chk("R2 low_power", {7'b0, low_power}, 8'h00);
        chk("R2 core_en", {7'b0, core_en}, 8'h01);

        // R5 power-down independent of sleep
        wr(8'h02);
        chk("R5 pde read", rd_ctrl, 8'h02);
        chk("R5 pde low_power", {7'b0, low_power}, 8'h01);
        wr(8'h12);
        cyc();
        chk("R5 both read", rd_ctrl, 8'h12);
        wr(8'h10);
        chk("R5 sleep only read", rd_ctrl, 8'h10);
        chk("R5 sleep holds low_power", {7'b0, low_power}, 8'h01);
        wr(8'h02);
        chk("R5 pde only read", rd_ctrl, 8'h02);
        chk("R5 pde holds low_power", {7'b0, low_power}, 8'h01);
        wr(8'h00);
        chk("R5 both clear low_power", {7'b0, low_power}, 8'h00);
        finish_resync("R5 sleep exit resync");
        wr(8'h02);
        wr(8'h00);
        chk("R5 pde exit without wait", {7'b0, core_en}, 8'h01);

        // R6 deferred soft reset
        frame_idle = 1'b0;
        wr(8'h0A);
        for (int k = 0; k < 3; k++) begin
            chk("R6 pending read", rd_ctrl, 8'h02);
            chk("R6 pending regs_clr", {7'b0, regs_clr}, 8'h00);
            cyc();
        end
        frame_idle = 1'b1;
        cyc();
        chk("R6 engaged read", rd_ctrl, 8'h09);
        chk("R6 regs_clr pulse", {7'b0, regs_clr}, 8'h01);
        cyc();
        chk("R6 regs_clr one cycle", {7'b0, regs_clr}, 8'h00);
        chk("R10 low_power after reset", {7'b0, low_power}, 8'h00);

        // R7 reset held until cleared; clearing when clear has no effect
        wr(8'h09);
        chk("R7 rewrite keeps reset", rd_ctrl, 8'h09);
        chk("R7 no second pulse", {7'b0, regs_clr}, 8'h00);
        wr(8'h01);
        chk("R7 reset removed init held", rd_ctrl, 8'h01);
        chk("R7 core_en with init", {7'b0, core_en}, 8'h00);
        wr(8'h01);
        for (int k = 0; k < 3; k++) begin
            chk("R7 clear-when-clear read", rd_ctrl, 8'h01);
            chk("R7 clear-when-clear regs_clr", {7'b0, regs_clr}, 8'h00);
            cyc();
        end
        wr(8'hE4);
        chk("R10 reserved bits read zero", rd_ctrl & 8'hE4, 8'h00);
        finish_resync("R8 init exit resync");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule